// File: doc/BRIEF.md
# Four-Channel DMA Transfer Scheduler

This block chooses which of four DMA channels receives the next transfer step. A periodic scheduling tick runs while the controller is enabled and at least one channel is unmasked. On each tick, or at once when a hardware request line rises, the block scans the channels in priority order. It grants the first eligible channel, and the transfer engine outside the block carries out the step. The engine then reports completion together with the number of clocks the step cost.

The cost of each step is added to a clock-debt counter. While that debt is non-zero, each periodic tick pays part of it off at a programmable rate and starts no scan. The transfer rate therefore follows the bus time the steps consume. The scan can start at channel 0 every time (fixed priority) or at a pointer that advances on every tick (rotating priority). In hold mode the scan continues past a served channel, so several channels can be served in one attempt. Grants are always issued one at a time.

Top module: `dmasched_top`

## Requirements
- R1: After reset, `grant` is 0, `busy` is 0 and `stalled` is 0.
- R2: While `cfg_disable` is 1, no grant is issued from the next cycle on, and the scheduler neither ticks nor scans.
- R3: A channel is eligible only when its latched hardware request or its `sw_req` bit is 1 and its `chan_mask` bit is 0. Bit i of each vector belongs to channel i.
- R4: With `cfg_rotate` at 0, every scan begins at channel 0 and visits channels in increasing index order. The lowest-numbered eligible channel is therefore granted first.
- R5: With `cfg_rotate` at 1, a scan begins at a pointer that increases by one modulo 4 on every periodic tick, whichever channel was served.
- R6: With `cfg_hold` at 0, a scan ends after its first completed step. With `cfg_hold` at 1, the channels that follow in scan order are visited in the same attempt, and each eligible one is granted in turn.
- R7: On `step_done`, `step_cost` is added to the debt, saturating at 2^DEBT_W-1. While the debt is non-zero no scan starts, and each periodic tick subtracts `pay_rate`, stopping at zero. `stalled` is 1 exactly while the debt is non-zero.
- R8: A periodic tick occurs every TICK_CYCLES cycles while the scheduler runs, meaning `cfg_disable` is 0 and at least one mask bit is 0. When it stops running, the debt is cleared, the rotation pointer returns to 0 and the tick counter restarts.
- R9: A 0-to-1 edge on `hw_req[i]` latches channel i's request and starts a scan without waiting for a tick, provided the block is idle and has no debt. A 1-to-0 edge clears the latch.
- R10: `grant` has at most one bit set. Once set, it stays unchanged until `step_done` arrives or the scheduler stops running.
- R11: `busy` is 1 from the cycle after a scan starts until the scan ends. Each rejected channel takes one cycle, and a granted channel holds `busy` until its completion.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_req | input | 4 | Hardware request lines, edge-latched per channel |
| sw_req | input | 4 | Software request levels per channel |
| chan_mask | input | 4 | Per-channel mask, 1 blocks the channel |
| cfg_disable | input | 1 | Stops all scheduling when 1 |
| cfg_rotate | input | 1 | 1 selects rotating priority, 0 fixed priority |
| cfg_hold | input | 1 | 1 lets one attempt serve several channels |
| pay_rate | input | PAY_W | Debt repaid per periodic tick |
| step_done | input | 1 | Transfer engine finished the granted step |
| step_cost | input | COST_W | Clocks consumed by the finished step |
| grant | output | 4 | One-hot grant to the channel being served |
| busy | output | 1 | A scan or a granted step is in progress |
| stalled | output | 1 | Clock debt is outstanding |

## Verification
The assertions check on every cycle that the grant is at most one-hot and stays stable while a step is in progress. They also check that disabling removes the grant, that no scan begins while debt is owed, that repayment stops at zero and that a stop clears the debt. Further checks cover the rotation pointer stepping on every tick and the request latch following each edge. Only the bench's scenarios can show the order-dependent outcomes: which channel wins under fixed or rotating priority, the full sequence a hold-mode attempt serves, the number of ticks debt repayment takes, and how many cycles an edge-triggered attempt needs to reach its grant.

// File: rtl/dmas_pkg.sv
package dmas_pkg;
    localparam int NUM_CH = 4;
    localparam int CH_W   = $clog2(NUM_CH);

    typedef logic [CH_W-1:0] chan_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SCAN  = 2'd1,
        ST_GRANT = 2'd2
    } sched_st_e;

    // Scan context: starting channel, scan position, channel being served
    typedef struct packed {
        chan_t base;
        chan_t step;
        chan_t chan;
    } scan_ctx_t;

    // Channel visited at a given scan position (wraps modulo NUM_CH)
    function automatic chan_t scan_chan(chan_t base, chan_t step);
        return chan_t'(base + step);
    endfunction
endpackage

// File: rtl/dmas_ticker.sv
module dmas_ticker
    import dmas_pkg::*;
#(
    parameter int TICK_CYCLES = 16
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    output logic  tick,
    output chan_t ptr
);
    localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
            ptr <= '0;
        end else begin
            cnt <= tick ? '0 : cnt + 1'b1;
            if (tick) ptr <= chan_t'(ptr + 1'b1);
        end
    end

    // R5: pointer steps by one on each tick
    a_r5_ptr_steps: assert property (@(posedge clk) disable iff (rst)
        tick |=> (ptr == chan_t'($past(ptr) + 1'b1)));

    // R8: ticks never fall on consecutive cycles
    a_r8_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick);

    // R8: stopping returns the pointer to zero
    a_r8_ptr_home: assert property (@(posedge clk) disable iff (rst)
        !run |=> (ptr == '0));
endmodule

// File: rtl/dmas_reqtrack.sv
module dmas_reqtrack
    import dmas_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hw_req,
    input  logic [NUM_CH-1:0] sw_req,
    input  logic [NUM_CH-1:0] chan_mask,
    output logic [NUM_CH-1:0] eligible,
    output logic              kick
);
    logic [NUM_CH-1:0] hw_q;
    logic [NUM_CH-1:0] latched;
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] fall;

    assign rise     = hw_req & ~hw_q;
    assign fall     = ~hw_req & hw_q;
    assign kick     = |rise;
    assign eligible = (latched | sw_req) & ~chan_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            hw_q    <= '0;
            latched <= '0;
        end else begin
            hw_q    <= hw_req;
            latched <= (latched | rise) & ~fall;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_edge_chk
        // R9: a rising line latches the request
        a_r9_rise_latch: assert property (@(posedge clk) disable iff (rst)
            (hw_req[g] && !hw_q[g]) |=> latched[g]);
        // R9: a falling line clears the request
        a_r9_fall_clear: assert property (@(posedge clk) disable iff (rst)
            (!hw_req[g] && hw_q[g]) |=> !latched[g]);
    end
endmodule

// File: rtl/dmas_debt.sv
module dmas_debt #(
    parameter int DEBT_W = 12,
    parameter int PAY_W  = 8,
    parameter int COST_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              pay,
    input  logic [PAY_W-1:0]  pay_amt,
    input  logic              charge,
    input  logic [COST_W-1:0] charge_amt,
    output logic              owing
);
    logic [DEBT_W-1:0] debt;
    logic [DEBT_W:0]   sum;
    logic [DEBT_W-1:0] pay_ext;

    assign sum     = {1'b0, debt} + (DEBT_W + 1)'(charge_amt);
    assign pay_ext = DEBT_W'(pay_amt);
    assign owing   = (debt != '0);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            debt <= '0;
        end else if (charge) begin
            debt <= sum[DEBT_W] ? '1 : sum[DEBT_W-1:0];
        end else if (pay) begin
            debt <= (debt > pay_ext) ? debt - pay_ext : '0;
        end
    end

    // R7: repayment floors at zero
    a_r7_floor: assert property (@(posedge clk) disable iff (rst)
        (pay && !charge && !clear && debt <= pay_ext) |=> (debt == '0));

    // R7: a charge never lowers the debt
    a_r7_charge_up: assert property (@(posedge clk) disable iff (rst)
        (charge && !clear) |=> (debt >= $past(debt)));

    // R8: stopping wipes the debt
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        clear |=> (debt == '0));
endmodule

// File: rtl/dmasched_top.sv
module dmasched_top
    import dmas_pkg::*;
#(
    parameter int TICK_CYCLES = 16,
    parameter int DEBT_W      = 12,
    parameter int PAY_W       = 8,
    parameter int COST_W      = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] hw_req,
    input  logic [NUM_CH-1:0] sw_req,
    input  logic [NUM_CH-1:0] chan_mask,
    input  logic              cfg_disable,
    input  logic              cfg_rotate,
    input  logic              cfg_hold,
    input  logic [PAY_W-1:0]  pay_rate,
    input  logic              step_done,
    input  logic [COST_W-1:0] step_cost,
    output logic [NUM_CH-1:0] grant,
    output logic              busy,
    output logic              stalled
);
    localparam chan_t LAST_STEP = chan_t'(NUM_CH - 1);

    logic              run;
    logic              tick;
    chan_t             ptr;
    logic [NUM_CH-1:0] eligible;
    logic              kick;
    logic              owing;
    logic              do_pay;
    logic              do_start;
    logic              do_charge;
    sched_st_e         st;
    scan_ctx_t         ctx;
    chan_t             probe;

    assign run   = !cfg_disable && !(&chan_mask);
    assign probe = scan_chan(ctx.base, ctx.step);

    dmas_ticker #(.TICK_CYCLES(TICK_CYCLES)) u_ticker (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .tick (tick),
        .ptr  (ptr)
    );

    dmas_reqtrack u_req (
        .clk       (clk),
        .rst       (rst),
        .hw_req    (hw_req),
        .sw_req    (sw_req),
        .chan_mask (chan_mask),
        .eligible  (eligible),
        .kick      (kick)
    );

    dmas_debt #(.DEBT_W(DEBT_W), .PAY_W(PAY_W), .COST_W(COST_W)) u_debt (
        .clk        (clk),
        .rst        (rst),
        .clear      (!run),
        .pay        (do_pay),
        .pay_amt    (pay_rate),
        .charge     (do_charge),
        .charge_amt (step_cost),
        .owing      (owing)
    );

    always_comb begin
        do_pay    = run && (st == ST_IDLE) && tick && owing;
        do_start  = run && (st == ST_IDLE) && (tick || kick) && !owing;
        do_charge = run && (st == ST_GRANT) && step_done;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            st  <= ST_IDLE;
            ctx <= '0;
        end else begin
            unique case (st)
                ST_IDLE: begin
                    if (do_start) begin
                        st       <= ST_SCAN;
                        ctx.base <= cfg_rotate ? ptr : '0;
                        ctx.step <= '0;
                    end
                end
                ST_SCAN: begin
                    if (eligible[probe]) begin
                        st       <= ST_GRANT;
                        ctx.chan <= probe;
                    end else if (ctx.step == LAST_STEP) begin
                        st <= ST_IDLE;
                    end else begin
                        ctx.step <= chan_t'(ctx.step + 1'b1);
                    end
                end
                ST_GRANT: begin
                    if (step_done) begin
                        if (cfg_hold && ctx.step != LAST_STEP) begin
                            st       <= ST_SCAN;
                            ctx.step <= chan_t'(ctx.step + 1'b1);
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_grant
        assign grant[g] = (st == ST_GRANT) && (ctx.chan == chan_t'(g));
    end

    assign busy    = (st != ST_IDLE);
    assign stalled = owing;

    // R10: never more than one grant
    a_r10_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant));

    // R10: a grant holds until its step completes
    a_r10_grant_held: assert property (@(posedge clk) disable iff (rst)
        (grant != '0 && !step_done && run) |=> $stable(grant));

    // R2: disabling removes any grant
    a_r2_off_no_grant: assert property (@(posedge clk) disable iff (rst)
        cfg_disable |=> (grant == '0));

    // R7: no scan begins while debt is owed
    a_r7_no_scan_in_debt: assert property (@(posedge clk) disable iff (rst)
        (st == ST_IDLE && stalled) |=> (st != ST_SCAN));

    // R6: without hold a completed step ends the attempt
    a_r6_single_step: assert property (@(posedge clk) disable iff (rst)
        (st == ST_GRANT && step_done && !cfg_hold && run) |=> (st == ST_IDLE));
endmodule

// File: tb/dmasched_top_bench.sv
module dmasched_top_bench;
    localparam int TICKS = 16;
    localparam int LAT   = 2;
    localparam int DMAX  = 4095;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] hw_req = '0;
    logic [3:0] sw_req = '0;
    logic [3:0] chan_mask = 4'hF;
    logic       cfg_disable = 1'b0;
    logic       cfg_rotate = 1'b0;
    logic       cfg_hold = 1'b0;
    logic [7:0] pay_rate = 8'd64;
    logic       step_done = 1'b0;
    logic [7:0] step_cost = '0;
    logic [3:0] grant;
    logic       busy;
    logic       stalled;

    int errors = 0;
    int checks = 0;
    int cyc_n = 0;

    always #4 clk = ~clk;

    dmasched_top u_dmasched_top (
        .clk(clk), .rst(rst), .hw_req(hw_req), .sw_req(sw_req),
        .chan_mask(chan_mask), .cfg_disable(cfg_disable),
        .cfg_rotate(cfg_rotate), .cfg_hold(cfg_hold), .pay_rate(pay_rate),
        .step_done(step_done), .step_cost(step_cost),
        .grant(grant), .busy(busy), .stalled(stalled)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc_n);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [3:0] m_req = '0, m_hwq = '0;
    int m_tcnt = 0, m_ptr = 0, m_debt = 0, m_st = 0, m_base = 0, m_k = 0, m_cur = 0;
    int wcnt = 0;

    always @(posedge clk) begin
        cyc_n++;
        if (rst) begin
            m_req = '0; m_hwq = '0; m_tcnt = 0; m_ptr = 0; m_debt = 0;
            m_st = 0; m_base = 0; m_k = 0; m_cur = 0;
        end else begin
            bit run, tck;
            logic [3:0] rise, fall, elig;
            run  = !cfg_disable && chan_mask != 4'hF;
            tck  = run && m_tcnt == TICKS - 1;
            rise = hw_req & ~m_hwq;
            fall = ~hw_req & m_hwq;
            elig = (m_req | sw_req) & ~chan_mask;
            if (!run) begin
                m_tcnt = 0; m_ptr = 0; m_debt = 0; m_st = 0;
            end else begin
                if (m_st == 0) begin
                    if (tck && m_debt > 0) begin
                        m_debt = m_debt - int'(pay_rate);
                        if (m_debt < 0) m_debt = 0;
                    end else if ((tck || rise != 0) && m_debt == 0) begin
                        m_st = 1; m_base = cfg_rotate ? m_ptr : 0; m_k = 0;
                    end
                end else if (m_st == 1) begin
                    int ch;
                    ch = (m_base + m_k) % 4;
                    if (elig[ch]) begin m_st = 2; m_cur = ch; end
                    else if (m_k == 3) m_st = 0;
                    else m_k++;
                end else begin
                    if (step_done) begin
                        m_debt = m_debt + int'(step_cost);
                        if (m_debt > DMAX) m_debt = DMAX;
                        if (cfg_hold && m_k != 3) begin m_k++; m_st = 1; end
                        else m_st = 0;
                    end
                end
                if (tck) m_ptr = (m_ptr + 1) % 4;
                m_tcnt = tck ? 0 : m_tcnt + 1;
            end
            m_req = (m_req | rise) & ~fall;
            m_hwq = hw_req;
        end
    end

    // ---------------- per-cycle compare, logs, step responder ----------------
    int glog_ch[$];
    int glog_t[$];
    int brise_t[$];
    logic [3:0] prev_grant = '0;
    logic prev_busy = 1'b0;

    always @(negedge clk) begin
        if (!rst) begin
            logic [3:0] eg;
            eg = (m_st == 2) ? 4'(1 << m_cur) : 4'h0;
            chk(grant === eg, "R4/R5/R6 grant vs model", int'(grant), int'(eg));
            chk(busy === (m_st != 0), "R11 busy vs model", int'(busy), int'(m_st != 0));
            chk(stalled === (m_debt != 0), "R7 stalled vs model", int'(stalled), int'(m_debt != 0));
            chk($countones(grant) <= 1, "R10 grant one-hot", $countones(grant), 1);
            if (grant != 0 && grant != prev_grant) begin
                for (int i = 0; i < 4; i++) if (grant[i]) glog_ch.push_back(i);
                glog_t.push_back(cyc_n);
            end
            if (busy && !prev_busy) brise_t.push_back(cyc_n);
            prev_grant = grant;
            prev_busy  = busy;
        end
        if (m_st == 2 && !rst) begin
            wcnt++;
            step_done = (wcnt == LAT);
        end else begin
            wcnt = 0;
            step_done = 1'b0;
        end
    end

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy);
    endtask

    task automatic clr_logs();
        glog_ch.delete(); glog_t.delete(); brise_t.delete();
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc_n, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // ---------------- scenarios ----------------
    initial begin
        cyc(4);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(grant == 0, "R1 grant after reset", int'(grant), 0);
        chk(busy == 0, "R1 busy after reset", int'(busy), 0);
        chk(stalled == 0, "R1 stalled after reset", int'(stalled), 0);

        // R2 disabled: nothing granted
        cfg_disable = 1; chan_mask = 4'h0; sw_req = 4'hF;
        clr_logs();
        cyc(100);
        chk(glog_ch.size() == 0, "R2 grants while disabled", glog_ch.size(), 0);
        chk(brise_t.size() == 0, "R2 scans while disabled", brise_t.size(), 0);

        // R4 fixed priority
        cfg_disable = 0; sw_req = 4'b0110; step_cost = 3; pay_rate = 64;
        wait_idle(); clr_logs();
        cyc(120);
        chk(glog_ch.size() > 0 && glog_ch[0] == 1, "R4 first grant channel",
            glog_ch.size() > 0 ? glog_ch[0] : -1, 1);
        begin
            int bad = 0;
            foreach (glog_ch[i]) if (glog_ch[i] != 1) bad++;
            chk(bad == 0, "R4 lowest eligible always wins", bad, 0);
        end

        // R3 mask blocks channel 1
        chan_mask = 4'b0010;
        wait_idle(); clr_logs();
        cyc(120);
        begin
            int bad = 0;
            foreach (glog_ch[i]) if (glog_ch[i] != 2) bad++;
            chk(glog_ch.size() > 0 && bad == 0, "R3 masked channel skipped", bad, 0);
        end

        // R5 rotating priority
        chan_mask = 4'h0; sw_req = 4'hF; step_cost = 0; cfg_rotate = 1;
        wait_idle(); clr_logs();
        cyc(160);
        begin
            int bad = 0;
            for (int i = 2; i < glog_ch.size(); i++)
                if (glog_ch[i] != (glog_ch[i-1] + 1) % 4) bad++;
            chk(glog_ch.size() >= 6 && bad == 0, "R5 rotation steps by one", bad, 0);
        end

        // R6 hold serves every channel in one attempt
        cfg_rotate = 0; cfg_hold = 1;
        cyc(20); wait_idle(); clr_logs();
        cyc(40);
        chk(glog_ch.size() >= 4 && glog_ch[0] == 0 && glog_ch[1] == 1 &&
            glog_ch[2] == 2 && glog_ch[3] == 3, "R6 hold order 0..3",
            glog_ch.size() >= 4 ? glog_ch[3] : -1, 3);
        chk(glog_t.size() >= 4 && glog_t[3] - glog_t[0] < TICKS, "R6 hold within one attempt",
            glog_t.size() >= 4 ? glog_t[3] - glog_t[0] : -1, LAT * 4);

        // R7 debt: cost 100, rate 30 -> four paying ticks, scan on fifth
        cfg_hold = 0; sw_req = 4'b0001; pay_rate = 30;
        cyc(40); wait_idle();
        step_cost = 100;
        clr_logs();
        cyc(200);
        chk(glog_t.size() >= 2 && glog_t[1] - glog_t[0] == 5 * TICKS, "R7 debt gap in cycles",
            glog_t.size() >= 2 ? glog_t[1] - glog_t[0] : -1, 5 * TICKS);
        step_cost = 0; sw_req = 4'h0;
        cyc(120);
        chk(stalled == 0, "R7 debt fully repaid", int'(stalled), 0);

        // R8 tick period
        wait_idle(); clr_logs();
        cyc(60);
        chk(brise_t.size() >= 2 && brise_t[1] - brise_t[0] == TICKS, "R8 tick period",
            brise_t.size() >= 2 ? brise_t[1] - brise_t[0] : -1, TICKS);

        // R9 rising edge triggers at once
        do @(negedge clk); while (!busy);
        wait_idle();
        hw_req = 4'b1000;
        begin
            int n = 0;
            while (n < 12 && grant != 4'b1000) begin @(negedge clk); n++; end
            chk(n == 5, "R9 edge-started grant latency", n, 5);
        end
        cyc(40);
        hw_req = 4'b0000;
        wait_idle(); clr_logs();
        cyc(60);
        chk(glog_ch.size() == 0, "R9 falling edge clears request", glog_ch.size(), 0);

        // R8 stopping clears debt
        sw_req = 4'b0001; step_cost = 200; pay_rate = 1;
        clr_logs();
        cyc(40);
        chk(stalled == 1, "R8 debt built up", int'(stalled), 1);
        chan_mask = 4'hF;
        cyc(2);
        chk(stalled == 0, "R8 stop clears debt", int'(stalled), 0);
        clr_logs();
        cyc(60);
        chk(brise_t.size() == 0, "R8 no activity when all masked", brise_t.size(), 0);
        chan_mask = 4'h0;
        cyc(30);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule